// File: doc/BRIEF.md
# Masked Interrupt Controller with Wake Output

This block collects up to 32 interrupt lines from peripherals and turns them into a single request towards a small processor core. Each line owns a pending bit in a status register, and a mask register selects which pending lines may reach the core. The request is further gated by the core's global interrupt-enable input. It changes state only at an instruction boundary, which the core signals with an instruction-complete input.

Software reaches both registers through a narrow register port. The port has a one-bit select, a write strobe, write data and read data returned in the same cycle. Three parameters select the variant. One chooses edge or level triggering. One makes lines 0 and 1 permanently unmasked. One disables the controller, so that raw line activity is forwarded to the core without touching any register. Every newly accepted interrupt also produces a one-cycle wake pulse, which the power manager uses to drop its doze and sleep enables.

Top module: `irq_ctrl`

## Requirements
- R1: After reset the status register reads 0, `cpu_irq` and `wake` are 0, and the mask register reads 0x00000003 when `NMI_PAIR` is set or 0x00000000 otherwise.
- R2: `cpu_irq` goes from 0 to 1 only on a clock edge where `insn_done` is 1 and the request condition holds. The request condition is: (mask AND status) is nonzero and `cpu_ie` is 1. `cpu_irq` returns to 0 on the first edge at which the condition is false.
- R3: In edge mode a 0-to-1 change on a line sets that line's status bit on the next clock edge, whether or not the line is masked.
- R4: A new assertion on a line whose status bit is already set is dropped. No wake pulse follows, and the status register keeps its value.
- R5: In edge mode, writing the status register (`reg_sel`=1) clears each bit written as 1 and leaves bits written as 0 unchanged. A rising edge in the same cycle as a clear of that bit leaves the bit set.
- R6: In level mode each status bit follows its input line one edge later, and software writes to the status register have no effect.
- R7: Every accepted interrupt produces `wake`=1 for exactly the one cycle after the edge that accepted it.
- R8: A mask write (`reg_sel`=0) that unmasks an already pending line causes `cpu_irq` to rise at the next instruction boundary after the write takes effect.
- R9: With `NMI_PAIR` set, mask bits 0 and 1 always read 1, even after software writes 0 to them.
- R10: With `CTRL_ON` clear, the status register stays 0. `cpu_irq` follows (any line high AND `cpu_ie`), taken at an instruction boundary.
- R11: `reg_rdata` returns the mask register when `reg_sel`=0 and the status register when `reg_sel`=1, in the same cycle without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | LINES | Interrupt lines, synchronous to clk |
| reg_sel | input | 1 | Register select: 0 mask, 1 status |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | LINES | Register write data |
| reg_rdata | output | LINES | Register read data (combinational) |
| cpu_ie | input | 1 | Global interrupt enable from the core |
| insn_done | input | 1 | Instruction boundary marker |
| cpu_irq | output | 1 | Interrupt request to the core |
| wake | output | 1 | One-cycle pulse that clears doze and sleep enables |

## Verification
The edge-triggered variant receives the following patterns. A masked line shows that status is set while the request stays low. A later mask write shows the re-evaluation. A held-off `insn_done` separates "pending" from "delivered". A dropped `cpu_ie` shows the global gate. A re-assertion on a pending line must produce neither a wake nor a status change. A rising edge that coincides with a clear shows which one wins. Lines 0 and 31 cover both ends of the vector. A level-triggered instance shows status tracking the pin while software clears are refused. A disabled instance shows requests forwarded with an untouched status register.

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
  parameter int LINES     = 32,
  parameter bit EDGE_TRIG = 1'b1,
  parameter bit NMI_PAIR  = 1'b1,
  parameter bit CTRL_ON   = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] irq_in,
  input  logic             reg_sel,
  input  logic             reg_we,
  input  logic [LINES-1:0] reg_wdata,
  output logic [LINES-1:0] reg_rdata,
  input  logic             cpu_ie,
  input  logic             insn_done,
  output logic             cpu_irq,
  output logic             wake
);
  localparam logic [LINES-1:0] FIXED_ON = NMI_PAIR ? LINES'(3) : '0;

  logic [LINES-1:0] mask_q, stat_q, prev_q;
  logic [LINES-1:0] stat_d, mask_d, hit, fresh, clr, keep;
  logic             req_now;

  assign hit   = EDGE_TRIG ? (irq_in & ~prev_q) : irq_in;
  assign fresh = CTRL_ON ? (hit & ~stat_q) : (irq_in & ~prev_q);
  assign clr   = (reg_we && reg_sel) ? reg_wdata : '0;
  assign keep  = stat_q & ~clr;

  always_comb begin
    if (!CTRL_ON)       stat_d = '0;
    else if (EDGE_TRIG) stat_d = keep | hit;
    else                stat_d = irq_in;
  end

  assign mask_d  = (reg_we && !reg_sel) ? (reg_wdata | FIXED_ON) : mask_q;
  assign req_now = cpu_ie && (CTRL_ON ? |(mask_q & stat_q) : |irq_in);
  assign reg_rdata = reg_sel ? stat_q : mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= FIXED_ON;
      stat_q  <= '0;
      prev_q  <= '0;
      cpu_irq <= 1'b0;
      wake    <= 1'b0;
    end else begin
      mask_q <= mask_d;
      stat_q <= stat_d;
      prev_q <= irq_in;
      wake   <= |fresh;
      if (!req_now)       cpu_irq <= 1'b0;
      else if (insn_done) cpu_irq <= 1'b1;
    end
  end

  a_r2_rise_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_irq) |-> ($past(insn_done) && $past(req_now)));

  a_r2_drop_without_request: assert property (@(posedge clk) disable iff (!rst_n)
    !req_now |=> !cpu_irq);

  a_r7_wake_needs_line: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> $past(|irq_in));

  generate
    if (NMI_PAIR) begin : g_nmi_chk
      a_r9_pair_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        mask_q[1:0] == 2'b11);
    end
    if (!CTRL_ON) begin : g_byp_chk
      a_r10_status_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stat_q == '0);
    end
    if (CTRL_ON && EDGE_TRIG) begin : g_edge_chk
      a_r4_pending_retained: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & $past(keep)) == $past(keep)));
    end
  endgenerate
endmodule

// File: tb/irq_ctrl_test.sv
module irq_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;

  logic [31:0] irq, wdata, rdata;
  logic sel, we, ie, done, irq_o, wake_o;
  irq_ctrl #(.LINES(32), .EDGE_TRIG(1'b1), .NMI_PAIR(1'b1), .CTRL_ON(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq), .reg_sel(sel), .reg_we(we),
    .reg_wdata(wdata), .reg_rdata(rdata), .cpu_ie(ie), .insn_done(done),
    .cpu_irq(irq_o), .wake(wake_o));

  logic [31:0] l_irq, l_wdata, l_rdata;
  logic l_sel, l_we, l_irq_o, l_wake;
  irq_ctrl #(.LINES(32), .EDGE_TRIG(1'b0), .NMI_PAIR(1'b0), .CTRL_ON(1'b1)) uut_lvl (
    .clk(clk), .rst_n(rst_n), .irq_in(l_irq), .reg_sel(l_sel), .reg_we(l_we),
    .reg_wdata(l_wdata), .reg_rdata(l_rdata), .cpu_ie(1'b1), .insn_done(1'b1),
    .cpu_irq(l_irq_o), .wake(l_wake));

  logic [31:0] b_irq, b_rdata;
  logic b_ie, b_irq_o, b_wake;
  irq_ctrl #(.LINES(32), .EDGE_TRIG(1'b1), .NMI_PAIR(1'b0), .CTRL_ON(1'b0)) uut_byp (
    .clk(clk), .rst_n(rst_n), .irq_in(b_irq), .reg_sel(1'b1), .reg_we(1'b0),
    .reg_wdata(32'h0), .reg_rdata(b_rdata), .cpu_ie(b_ie), .insn_done(1'b1),
    .cpu_irq(b_irq_o), .wake(b_wake));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic s, input logic [31:0] d);
    sel = s; we = 1'b1; wdata = d;
    step();
    we = 1'b0; wdata = '0;
  endtask

  task automatic t_reset();
    sel = 1'b0; #1;
    chk("R1 mask after reset", rdata, 32'h3);
    sel = 1'b1; #1;
    chk("R1 status after reset", rdata, 32'h0);
    chk("R1 request after reset", {31'b0, irq_o}, 32'h0);
    chk("R1 wake after reset", {31'b0, wake_o}, 32'h0);
    l_sel = 1'b0; #1;
    chk("R1 level mask after reset", l_rdata, 32'h0);
  endtask

  task automatic t_masked_edge();
    irq[5] = 1'b1;
    step();
    sel = 1'b1; #1;
    chk("R3 masked line sets status", rdata, 32'h20);
    chk("R7 wake after accept", {31'b0, wake_o}, 32'h1);
    irq[5] = 1'b0;
    step();
    chk("R7 wake lasts one cycle", {31'b0, wake_o}, 32'h0);
    chk("R2 masked line no request", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_unmask();
    wr(1'b0, 32'h20);
    chk("R8 request not yet raised", {31'b0, irq_o}, 32'h0);
    step();
    chk("R8 unmask raises request", {31'b0, irq_o}, 32'h1);
    sel = 1'b0; #1;
    chk("R11 mask read", rdata, 32'h23);
  endtask

  task automatic t_boundary();
    wr(1'b1, 32'h20);
    sel = 1'b1; #1;
    chk("R5 write-one clears status", rdata, 32'h0);
    step();
    chk("R2 request drops", {31'b0, irq_o}, 32'h0);
    done = 1'b0;
    irq[5] = 1'b1;
    step();
    irq[5] = 1'b0;
    step();
    chk("R2 held off without boundary", {31'b0, irq_o}, 32'h0);
    step();
    chk("R2 still held off", {31'b0, irq_o}, 32'h0);
    done = 1'b1;
    step();
    chk("R2 raised at boundary", {31'b0, irq_o}, 32'h1);
    ie = 1'b0;
    step();
    chk("R2 global enable gates request", {31'b0, irq_o}, 32'h0);
    ie = 1'b1;
    wr(1'b1, 32'h20);
    step();
  endtask

  task automatic t_repeat();
    irq[7] = 1'b1;
    step();
    chk("R7 wake on line 7", {31'b0, wake_o}, 32'h1);
    irq[7] = 1'b0;
    step();
    irq[7] = 1'b1;
    step();
    chk("R4 repeat gives no wake", {31'b0, wake_o}, 32'h0);
    sel = 1'b1; #1;
    chk("R4 repeat leaves status", rdata, 32'h80);
    irq[7] = 1'b0;
    wr(1'b1, 32'h80);
    sel = 1'b1; #1;
    chk("R5 clear of line 7", rdata, 32'h0);
  endtask

  task automatic t_set_wins();
    irq[9] = 1'b1; irq[10] = 1'b1;
    step();
    irq[9] = 1'b0;
    wr(1'b1, 32'h0);
    irq[9] = 1'b1;
    wr(1'b1, 32'h600);
    sel = 1'b1; #1;
    chk("R5 set beats clear", rdata, 32'h200);
    irq[9] = 1'b0; irq[10] = 1'b0;
    wr(1'b1, 32'h200);
    step();
  endtask

  task automatic t_ends_nmi();
    wr(1'b0, 32'h0);
    sel = 1'b0; #1;
    chk("R9 pair stays unmasked", rdata, 32'h3);
    irq[31] = 1'b1;
    step();
    sel = 1'b1; #1;
    chk("R3 top line sets status", rdata, 32'h8000_0000);
    step();
    chk("R2 top line masked", {31'b0, irq_o}, 32'h0);
    irq[31] = 1'b0;
    irq[0] = 1'b1;
    step();
    step();
    chk("R9 line 0 requests", {31'b0, irq_o}, 32'h1);
    irq[0] = 1'b0;
    wr(1'b1, 32'h8000_0001);
    step();
    chk("R2 drop after clearing line 0", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_level();
    l_irq[3] = 1'b1;
    step();
    l_sel = 1'b1; #1;
    chk("R6 level status follows", l_rdata, 32'h8);
    chk("R7 level wake", {31'b0, l_wake}, 32'h1);
    l_sel = 1'b1; l_we = 1'b1; l_wdata = 32'h8;
    step();
    l_we = 1'b0;
    chk("R6 clear ignored while high", l_rdata, 32'h8);
    chk("R4 level held no new wake", {31'b0, l_wake}, 32'h0);
    l_irq[3] = 1'b0;
    step();
    chk("R6 status drops with line", l_rdata, 32'h0);
  endtask

  task automatic t_bypass();
    b_irq[2] = 1'b1;
    step();
    chk("R10 bypass forwards request", {31'b0, b_irq_o}, 32'h1);
    chk("R10 bypass status stays zero", b_rdata, 32'h0);
    b_ie = 1'b0;
    step();
    chk("R10 bypass gated by enable", {31'b0, b_irq_o}, 32'h0);
    b_irq[2] = 1'b0;
    b_ie = 1'b1;
    step();
  endtask

  initial begin
    irq = '0; wdata = '0; sel = 1'b0; we = 1'b0; ie = 1'b1; done = 1'b1;
    l_irq = '0; l_wdata = '0; l_sel = 1'b0; l_we = 1'b0;
    b_irq = '0; b_ie = 1'b1;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_masked_edge();
    t_unmask();
    t_boundary();
    t_repeat();
    t_set_wins();
    t_ends_nmi();
    t_level();
    t_bypass();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule